// File: doc/BRIEF.md
# EDO DRAM Device Interface Model

This block models the device side of an asynchronous extended-data-out DRAM. The address bus is multiplexed, and each byte lane has its own column strobe. A fast system clock samples the active-low strobes: row strobe, lower and upper column strobes, write enable and output enable. The model compares each sample with the one before it to find edges. It latches the row address and then the column address, and reads or writes words or single bytes in a small parameterised array. It drives a 16-bit read bus with one output enable per byte lane.

Column-before-row strobe ordering starts a refresh-only cycle. In that cycle an internal row pointer chooses the row and the address bus is ignored. A row cycle with both column strobes high refreshes the addressed row. Refresh does not model cell decay. It only advances the pointer and sets a bit in a per-row "refreshed" mask.

Each input sample takes effect on the outputs one clock after the edge that captured it. The row index is the row address modulo `ROWS`. The column index is the column address modulo `COLS`.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, `dout_en` is 00, `dout` is 0, `rfsh_ptr` is 0 and `fresh_rows` is all zero. Every array word reads as zero.
- R2: The row is captured on the clock that first sees `ras_n` low while both column strobes are high. The column is captured on the clock that first sees either column strobe low. A word written at a row and column reads back unchanged.
- R3: Lane 0 is `dout`/`din` bits 7:0 and is gated by `lcas_n`. Lane 1 is bits 15:8 and is gated by `ucas_n`. A write leaves the lane whose strobe is high unchanged. A read enables only the lanes whose strobe went low, and a disabled lane drives 0 on `dout`.
- R4: The internal column strobe is active from the first lane strobe falling until the last one rises. A second lane strobe that falls later does not capture a new column. It joins that lane to the ongoing read.
- R5: With `we_n` high, read data is driven only once both the column strobe and `oe_n` are low. The later of the two falls starts the output.
- R6: After the column strobe rises, read data and its lane enables are held until the next column strobe fall, which loads the newly addressed column. With `ras_n` and both column strobes high, `dout_en` is 00.
- R7: `oe_n` sampled high gives `dout_en` 00 on the next clock. Taking `oe_n` low again drives the held data again.
- R8: With `we_n` low when the column strobe falls (early write), `din` is written to the selected lanes and `dout_en` stays 00.
- R9: With `we_n` falling while the column strobe is low (late write), `din` is written at the captured column and the outputs turn off.
- R10: A column strobe low when `ras_n` falls starts a refresh-only cycle. The row at `rfsh_ptr` is marked in `fresh_rows` and `rfsh_ptr` steps by one, modulo `ROWS`. The address and `we_n` have no effect, and `dout_en` stays 00.
- R11: A row cycle with both column strobes high sets the addressed row's bit in `fresh_rows`. It leaves `rfsh_ptr` unchanged and keeps `dout_en` at 00. Bits of `fresh_rows` are never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lane 0 column strobe, active low |
| ucas_n | input | 1 | Lane 1 column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 2*BYTE_W | Write data |
| dout | output | 2*BYTE_W | Read data, zero on disabled lanes |
| dout_en | output | 2 | Per-lane output enable |
| rfsh_ptr | output | $clog2(ROWS) | Internal refresh row pointer |
| fresh_rows | output | ROWS | One bit per row, set once the row is refreshed |

## Verification
The bench builds the model with `ROWS` = 4 and `COLS` = 8. With four rows, four refresh-only cycles wrap the refresh pointer. The refreshed mask is small enough to compare whole, so a bench check can show that the address bus was ignored during refresh.

The eight columns let one open row hold several distinct words for page-mode reads. The address bus keeps its full 9-bit width, which also exercises the modulo reduction of row and column indices.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_ACCESS = 2'd1,
      CYC_CBR    = 2'd2
   } cyc_e;

   localparam int LANES = 2;
endpackage

// File: rtl/edo_strobe_edge.sv
module edo_strobe_edge #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_n,
   output logic [W-1:0] fell
);
   logic [W-1:0] prev_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n <= '1;
      else        prev_n <= lvl_n;
   end

   assign fell = prev_n & ~lvl_n;
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
   parameter int ROWS = 8,
   localparam int RW = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cbr_go,
   input  logic            mark_go,
   input  logic [RW-1:0]   mark_row,
   output logic [RW-1:0]   ptr,
   output logic [ROWS-1:0] fresh
);
   logic [RW-1:0] ptr_inc;

   generate
      if (ROWS == (1 << RW)) begin : g_pow2_wrap
         assign ptr_inc = ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign ptr_inc = (ptr == RW'(ROWS - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         fresh <= '0;
      end else begin
         if (cbr_go) begin
            ptr        <= ptr_inc;
            fresh[ptr] <= 1'b1;
         end else if (mark_go) begin
            fresh[mark_row] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   parameter int BYTE_W = 8,
   localparam int NL    = edo_pkg::LANES,
   localparam int DW    = BYTE_W * NL,
   localparam int RW    = $clog2(ROWS),
   localparam int CW    = $clog2(COLS),
   localparam int DEPTH = ROWS * COLS,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_go,
   input  logic [NL-1:0] wr_lane,
   input  logic [RW-1:0] wr_row,
   input  logic [CW-1:0] wr_col,
   input  logic [DW-1:0] wr_data,
   input  logic [RW-1:0] rd_row,
   input  logic [CW-1:0] rd_col,
   output logic [DW-1:0] rd_data
);
   logic [AW-1:0] wr_idx, rd_idx;

   assign wr_idx = AW'(wr_row) * AW'(COLS) + AW'(wr_col);
   assign rd_idx = AW'(rd_row) * AW'(COLS) + AW'(rd_col);

   for (genvar g = 0; g < NL; g++) begin : g_bank
      logic [BYTE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
         end else if (wr_go && wr_lane[g]) begin
            bank[wr_idx] <= wr_data[g*BYTE_W +: BYTE_W];
         end
      end

      assign rd_data[g*BYTE_W +: BYTE_W] = bank[rd_idx];
   end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
   parameter int ADDR_W = 9,
   parameter int BYTE_W = 8,
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   localparam int DW    = BYTE_W * edo_pkg::LANES,
   localparam int RW    = $clog2(ROWS),
   localparam int CW    = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              lcas_n,
   input  logic              ucas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     din,
   output logic [DW-1:0]     dout,
   output logic [1:0]        dout_en,
   output logic [RW-1:0]     rfsh_ptr,
   output logic [ROWS-1:0]   fresh_rows
);
   import edo_pkg::*;

   if (ROWS < 2 || COLS < 2) begin : g_chk_size
      $error("edo_dram_model: ROWS and COLS must be at least 2");
   end
   if (ROWS > (1 << ADDR_W) || COLS > (1 << ADDR_W)) begin : g_chk_addr
      $error("edo_dram_model: array larger than address reach");
   end
   if (BYTE_W < 1) begin : g_chk_byte
      $error("edo_dram_model: BYTE_W must be positive");
   end

   function automatic logic [RW-1:0] row_of(input logic [ADDR_W-1:0] a);
      return RW'(a % ADDR_W'(ROWS));
   endfunction
   function automatic logic [CW-1:0] col_of(input logic [ADDR_W-1:0] a);
      return CW'(a % ADDR_W'(COLS));
   endfunction

   // edge detection: {cas_int, we, ucas, lcas, ras}
   logic [4:0] fell;
   logic       cas_any;
   logic [1:0] lanes_lo;

   assign cas_any  = ~(lcas_n & ucas_n);
   assign lanes_lo = ~{ucas_n, lcas_n};

   edo_strobe_edge #(.W(5)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_n ({~cas_any, we_n, ucas_n, lcas_n, ras_n}),
      .fell  (fell)
   );

   logic ras_fall, cas_fall, we_fall;
   logic [1:0] lane_fall;
   assign ras_fall  = fell[0];
   assign lane_fall = fell[2:1];
   assign we_fall   = fell[3];
   assign cas_fall  = fell[4];

   cyc_e          cyc_q;
   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;
   logic          read_act, oe_q;
   logic [1:0]    lane_sel;
   logic [DW-1:0] out_q, rd_data;

   logic cbr_go, acc_go, in_acc, rd_start, wr_early, wr_late, wr_go;
   logic [CW-1:0] wr_col;

   assign cbr_go   = ras_fall & cas_any;
   assign acc_go   = ras_fall & ~cas_any;
   assign in_acc   = (cyc_q == CYC_ACCESS) & ~ras_n;
   assign rd_start = in_acc & cas_fall & we_n;
   assign wr_early = in_acc & cas_fall & ~we_n;
   assign wr_late  = in_acc & we_fall & cas_any & ~cas_fall;
   assign wr_go    = wr_early | wr_late;
   assign wr_col   = cas_fall ? col_of(addr) : col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= CYC_IDLE;
         row_q <= '0;
         col_q <= '0;
      end else begin
         if (ras_n)       cyc_q <= CYC_IDLE;
         else if (cbr_go) cyc_q <= CYC_CBR;
         else if (acc_go) cyc_q <= CYC_ACCESS;
         if (acc_go) row_q <= row_of(addr);
         if (in_acc && cas_fall) col_q <= col_of(addr);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         read_act <= 1'b0;
         lane_sel <= '0;
         out_q    <= '0;
         oe_q     <= 1'b1;
      end else begin
         oe_q <= oe_n;
         if (cbr_go)                   read_act <= 1'b0;
         else if (ras_n && !cas_any)   read_act <= 1'b0;
         else if (!we_n)               read_act <= 1'b0;
         else if (rd_start)            read_act <= 1'b1;
         if (in_acc && cas_fall)          lane_sel <= lanes_lo;
         else if (read_act && cas_any)    lane_sel <= lane_sel | lane_fall;
         if (rd_start) out_q <= rd_data;
      end
   end

   edo_cell_array #(
      .ROWS(ROWS), .COLS(COLS), .BYTE_W(BYTE_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_go   (wr_go),
      .wr_lane (lanes_lo),
      .wr_row  (row_q),
      .wr_col  (wr_col),
      .wr_data (din),
      .rd_row  (row_q),
      .rd_col  (col_of(addr)),
      .rd_data (rd_data)
   );

   edo_refresh_ctr #(.ROWS(ROWS)) u_refresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .cbr_go   (cbr_go),
      .mark_go  (acc_go),
      .mark_row (row_of(addr)),
      .ptr      (rfsh_ptr),
      .fresh    (fresh_rows)
   );

   assign dout_en = {2{read_act & ~oe_q}} & lane_sel;

   for (genvar g = 0; g < 2; g++) begin : g_out
      assign dout[g*BYTE_W +: BYTE_W] = dout_en[g] ? out_q[g*BYTE_W +: BYTE_W] : '0;
   end
endmodule

// File: rtl/edo_dram_sva.sv
module edo_dram_sva #(
   parameter int ADDR_W = 9,
   parameter int BYTE_W = 8,
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   localparam int DW    = BYTE_W * 2,
   localparam int RW    = $clog2(ROWS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              lcas_n,
   input logic              ucas_n,
   input logic              we_n,
   input logic              oe_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DW-1:0]     din,
   input logic [DW-1:0]     dout,
   input logic [1:0]        dout_en,
   input logic [RW-1:0]     rfsh_ptr,
   input logic [ROWS-1:0]   fresh_rows
);
   logic ras_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ras_seen <= 1'b1;
      else        ras_seen <= ras_n;
   end

   function automatic logic [RW-1:0] step(input logic [RW-1:0] p);
      return (p == RW'(ROWS - 1)) ? '0 : p + 1'b1;
   endfunction
   function automatic logic [RW-1:0] ridx(input logic [ADDR_W-1:0] a);
      return RW'(a % ADDR_W'(ROWS));
   endfunction

   logic unused_ok;
   assign unused_ok = ^{din, dout, COLS};

   assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> dout_en == 2'b00);

   assert_we_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> dout_en == 2'b00);

   assert_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && lcas_n && ucas_n) |=> dout_en == 2'b00);

   assert_cbr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_seen && !ras_n && !(lcas_n && ucas_n))
      |=> (rfsh_ptr == step($past(rfsh_ptr))) && (dout_en == 2'b00));

   assert_ronly_mark_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_seen && !ras_n && lcas_n && ucas_n)
      |=> $stable(rfsh_ptr) && fresh_rows[ridx($past(addr))]);

   assert_fresh_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fresh_rows & $past(fresh_rows)) == $past(fresh_rows));
endmodule

bind edo_dram_model edo_dram_sva #(
   .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .ROWS(ROWS), .COLS(COLS)
) u_sva (.*);

// File: tb/sim_edo_dram_model.sv
module sim_edo_dram_model;
   localparam int ADDR_W = 9;
   localparam int ROWS   = 4;
   localparam int COLS   = 8;
   localparam int RW     = $clog2(ROWS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic [1:0]  dout_en;
   logic [RW-1:0] rfsh_ptr;
   logic [ROWS-1:0] fresh_rows;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   edo_dram_model #(.ADDR_W(ADDR_W), .BYTE_W(8), .ROWS(ROWS), .COLS(COLS)) u0 (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
      .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
      .dout_en(dout_en), .rfsh_ptr(rfsh_ptr), .fresh_rows(fresh_rows)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
      tick(); tick();
   endtask

   task automatic early_write(input int row, input int col, input logic [15:0] d,
                              input logic [1:0] lanes);
      ras_n = 0; addr = ADDR_W'(row); tick();
      addr = ADDR_W'(col); din = d; we_n = 0; oe_n = 0;
      lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; tick();
      check("R8 early write keeps outputs off", 32'(dout_en), 32'd0);
      lcas_n = 1; ucas_n = 1; we_n = 1; tick();
      idle();
   endtask

   task automatic read_chk(input string tag, input int row, input int col,
                           input logic [1:0] lanes, input logic [15:0] exp);
      ras_n = 0; addr = ADDR_W'(row); oe_n = 0; tick();
      addr = ADDR_W'(col); lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; tick();
      check({tag, " lane enables"}, 32'(dout_en), 32'(lanes));
      check({tag, " data"}, 32'(dout), 32'(exp));
      idle();
   endtask

   task automatic t_reset();
      check("R1 reset dout_en", 32'(dout_en), 32'd0);
      check("R1 reset dout", 32'(dout), 32'd0);
      check("R1 reset ptr", 32'(rfsh_ptr), 32'd0);
      check("R1 reset fresh", 32'(fresh_rows), 32'd0);
      read_chk("R1 array zero", 0, 5, 2'b11, 16'h0000);
   endtask

   task automatic t_word();
      early_write(1, 2, 16'hA5C3, 2'b11);
      early_write(1, 3, 16'h1234, 2'b11);
      early_write(2, 7, 16'h0F0F, 2'b11);
      read_chk("R2 word 1/2", 1, 2, 2'b11, 16'hA5C3);
      read_chk("R2 word 1/3", 1, 3, 2'b11, 16'h1234);
      read_chk("R2 word 2/7 via aliased address", 6, 15, 2'b11, 16'h0F0F);
   endtask

   task automatic t_bytes();
      early_write(1, 2, 16'h7E99, 2'b10);
      read_chk("R3 lower lane only", 1, 2, 2'b01, 16'h00C3);
      read_chk("R3 upper lane only", 1, 2, 2'b10, 16'h7E00);
      read_chk("R3 word after byte write", 1, 2, 2'b11, 16'h7EC3);
   endtask

   task automatic t_combined_cas();
      ras_n = 0; addr = 1; oe_n = 0; tick();
      addr = 2; lcas_n = 0; tick();
      check("R4 first lane enables", 32'(dout_en), 32'b01);
      addr = 5; ucas_n = 0; tick();
      check("R4 late lane joins", 32'(dout_en), 32'b11);
      check("R4 column kept from first fall", 32'(dout), 32'h7EC3);
      lcas_n = 1; tick();
      check("R4 strobe active until last rises", 32'(dout_en), 32'b11);
      idle();
   endtask

   task automatic t_oe();
      ras_n = 0; addr = 1; tick();
      addr = 2; lcas_n = 0; ucas_n = 0; tick();
      check("R5 OE high at column fall", 32'(dout_en), 32'b00);
      oe_n = 0; tick();
      check("R5 OE fall starts output", 32'(dout_en), 32'b11);
      check("R5 data", 32'(dout), 32'h7EC3);
      oe_n = 1; tick();
      check("R7 OE high turns off", 32'(dout_en), 32'b00);
      oe_n = 0; tick();
      check("R7 OE low drives again", 32'(dout), 32'h7EC3);
      idle();
   endtask

   task automatic t_edo();
      ras_n = 0; addr = 1; oe_n = 0; tick();
      addr = 2; lcas_n = 0; ucas_n = 0; tick();
      lcas_n = 1; ucas_n = 1; addr = 3; tick();
      check("R6 hold enables after rise", 32'(dout_en), 32'b11);
      check("R6 hold data after rise", 32'(dout), 32'h7EC3);
      lcas_n = 0; ucas_n = 0; tick();
      check("R6 next fall loads column", 32'(dout), 32'h1234);
      lcas_n = 1; ucas_n = 1; ras_n = 1; tick();
      check("R6 all high ends drive", 32'(dout_en), 32'b00);
      idle();
   endtask

   task automatic t_late_write();
      ras_n = 0; addr = 2; oe_n = 0; tick();
      addr = 4; lcas_n = 0; ucas_n = 0; tick();
      check("R9 read before write", 32'(dout), 32'h0000);
      check("R9 read enabled", 32'(dout_en), 32'b11);
      din = 16'hBEEF; we_n = 0; addr = 0; tick();
      check("R9 late write turns off", 32'(dout_en), 32'b00);
      idle();
      read_chk("R9 late write stored", 2, 4, 2'b11, 16'hBEEF);
   endtask

   task automatic t_refresh();
      lcas_n = 0; tick();
      ras_n = 0; addr = 3; we_n = 0; din = 16'hDEAD; tick();
      check("R10 pointer steps", 32'(rfsh_ptr), 32'd1);
      check("R10 address ignored in mask", 32'(fresh_rows), 32'b0111);
      check("R10 outputs off", 32'(dout_en), 32'b00);
      idle();
      read_chk("R10 no write in refresh", 1, 2, 2'b11, 16'h7EC3);
      ras_n = 0; addr = 3; tick();
      check("R11 row marked", 32'(fresh_rows), 32'b1111);
      check("R11 pointer unchanged", 32'(rfsh_ptr), 32'd1);
      check("R11 outputs off", 32'(dout_en), 32'b00);
      idle();
      for (int k = 2; k <= 4; k++) begin
         ucas_n = 0; tick();
         ras_n = 0; tick();
         check("R10 pointer wraps modulo rows", 32'(rfsh_ptr), 32'(k % ROWS));
         idle();
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      tick();
      t_reset();
      t_word();
      t_bytes();
      t_combined_cas();
      t_oe();
      t_edo();
      t_late_write();
      t_refresh();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule